// File: doc/BRIEF.md
# Burst Cache Line Refill Engine

This block fetches one complete cache line from a slower main memory when a cache controller reports a miss. The controller presents any byte address and pulses a start strobe. The engine then works on the line that holds that byte, never on the byte alone. It raises a read request towards memory for a fixed setup interval. After that it collects consecutive 32-bit data words, each qualified by a valid input, and places them one after another into a 64-byte line buffer.

When the last word has been stored, the engine pulses done for one cycle with the assembled line on its output. It also reports how many clock cycles the refill took, counted from the cycle it accepted the request. A start pulse that arrives while a refill is in progress is dropped.

The controller is a four-state machine. The states are ST_IDLE, ST_SETUP, ST_BURST and ST_DONE, and the transitions are:
- ACCEPT: ST_IDLE to ST_SETUP, on a start pulse.
- SETUP_OVER: ST_SETUP to ST_BURST, after the setup interval.
- LAST_BEAT: ST_BURST to ST_DONE, when a valid word is taken into the final slot.
- RELEASE: ST_DONE to ST_IDLE, unconditionally.

Top module: `refill_engine`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are low and cycles_o reads 0.
- R2: A start_i pulse seen in ST_IDLE is accepted. mem_addr_o then shows addr_i with its low 6 bits cleared, and it stays unchanged until the refill ends.
- R3: mem_req_o goes high in the cycle after acceptance and stays high for exactly 10 cycles (ST_SETUP). mem_valid_i is ignored during that interval.
- R4: In ST_BURST a data word is captured only in a cycle where mem_valid_i is high. A cycle with mem_valid_i low captures nothing and adds one cycle to the refill.
- R5: The k-th captured word (k = 0..15) lands in line_o bits [32k+31:32k]. This means line byte 4k is the word's bits [7:0] and line byte 4k+3 is its bits [31:24].
- R6: done_o is high for exactly one cycle, which is the cycle after the sixteenth word is captured. line_o holds the whole line in that cycle.
- R7: busy_o is high from the cycle after acceptance through the done cycle, and low in the next cycle.
- R8: A start_i pulse while busy_o is high has no effect. It does not change mem_addr_o, the line contents or the cycle count, and it does not start a second refill.
- R9: In the done cycle, cycles_o equals 26 plus the number of ST_BURST cycles that had mem_valid_i low. It keeps that value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Refill request strobe from the cache controller |
| addr_i | input | 32 | Byte address that missed |
| busy_o | output | 1 | Refill in progress |
| done_o | output | 1 | One-cycle pulse: line_o is complete |
| line_o | output | 512 | Assembled line, word k at bits [32k+31:32k] |
| cycles_o | output | 16 | Cycles taken by the latest refill |
| mem_req_o | output | 1 | Burst read request, held through setup |
| mem_addr_o | output | 32 | Line-aligned address of the burst |
| mem_valid_i | input | 1 | Qualifies mem_data_i |
| mem_data_i | input | 32 | Burst data word |

## Verification
Refills are run for a sweep of addresses, including some with non-zero low bits, so that the line alignment and the byte order of each word can be told apart. Every word carries four distinct bytes that encode its beat number, so a swapped slot or a reversed byte order is caught. For each address the memory model uses gap patterns of none, leading, alternating and late, and these separate true valid qualification from simple beat counting; they also check that the cycle count grows by the gap count. Further runs drive junk valid data during setup, or a second start during setup, during the burst or during the done cycle, to show that those inputs leave the line, the address and the count unchanged.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_BURST = 2'd2,
        ST_DONE  = 2'd3
    } refill_state_e;

endpackage

// File: rtl/refill_seq.sv
module refill_seq
    import refill_pkg::*;
#(
    parameter int SETUP_CYC = 10,
    parameter int BEATS     = 16,
    localparam int SET_W    = $clog2(SETUP_CYC + 1),
    localparam int BEAT_W   = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mem_valid_i,
    output logic              accept_o,
    output logic              mem_req_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              run_o,
    output logic              wr_en_o,
    output logic [BEAT_W-1:0] wr_idx_o
);

    refill_state_e state, nxt;
    logic [SET_W-1:0]  setup_cnt;
    logic [BEAT_W-1:0] beat_idx;
    logic              setup_last;
    logic              beat_last;

    assign setup_last = (setup_cnt == SET_W'(SETUP_CYC - 1));
    assign beat_last  = (beat_idx == BEAT_W'(BEATS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_i)                  nxt = ST_SETUP; // ACCEPT
            ST_SETUP: if (setup_last)               nxt = ST_BURST; // SETUP_OVER
            ST_BURST: if (mem_valid_i && beat_last) nxt = ST_DONE;  // LAST_BEAT
            ST_DONE:                                nxt = ST_IDLE;  // RELEASE
        endcase
    end

    // setup timer and beat slot pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_cnt <= '0;
            beat_idx  <= '0;
        end else begin
            if (state == ST_IDLE) begin
                setup_cnt <= '0;
                beat_idx  <= '0;
            end else if (state == ST_SETUP && !setup_last) begin
                setup_cnt <= setup_cnt + 1'b1;
            end else if (state == ST_BURST && mem_valid_i) begin
                beat_idx <= beat_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        accept_o  = 1'b0;
        mem_req_o = 1'b0;
        busy_o    = 1'b0;
        done_o    = 1'b0;
        run_o     = 1'b0;
        wr_en_o   = 1'b0;
        unique case (state)
            ST_IDLE:  accept_o = start_i;
            ST_SETUP: begin
                mem_req_o = 1'b1;
                busy_o    = 1'b1;
                run_o     = 1'b1;
            end
            ST_BURST: begin
                busy_o  = 1'b1;
                run_o   = 1'b1;
                wr_en_o = mem_valid_i;
            end
            ST_DONE: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
        endcase
    end

    assign wr_idx_o = beat_idx;

endmodule

// File: rtl/refill_pack.sv
module refill_pack #(
    parameter int WORD_W  = 32,
    parameter int BEATS   = 16,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int LINE_W = WORD_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BEAT_W-1:0] wr_idx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [LINE_W-1:0] line_o
);

    for (genvar k = 0; k < BEATS; k++) begin : g_slot
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   word_q <= '0;
            else if (wr_en_i && wr_idx_i == BEAT_W'(k))   word_q <= wr_data_i;
        end
        assign line_o[k*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/refill_meter.sv
module refill_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cycles_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cycles_o <= '0;
        else if (clear_i)               cycles_o <= '0;
        else if (run_i && !(&cycles_o)) cycles_o <= cycles_o + 1'b1;
    end

endmodule

// File: rtl/refill_engine.sv
module refill_engine #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETUP_CYC  = 10,
    parameter int CNT_W      = 16,
    localparam int BEATS     = LINE_BYTES * 8 / WORD_W,
    localparam int BEAT_W    = $clog2(BEATS),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [LINE_W-1:0] line_o,
    output logic [CNT_W-1:0]  cycles_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [WORD_W-1:0] mem_data_i
);

    logic              accept;
    logic              run;
    logic              wr_en;
    logic [BEAT_W-1:0] wr_idx;

    refill_seq #(
        .SETUP_CYC (SETUP_CYC),
        .BEATS     (BEATS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mem_valid_i (mem_valid_i),
        .accept_o    (accept),
        .mem_req_o   (mem_req_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .run_o       (run),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx)
    );

    refill_pack #(
        .WORD_W (WORD_W),
        .BEATS  (BEATS)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (mem_data_i),
        .line_o    (line_o)
    );

    refill_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .run_i    (run),
        .cycles_o (cycles_o)
    );

    // line-aligned burst address, latched only on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mem_addr_o <= '0;
        else if (accept) mem_addr_o <= {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

endmodule

// File: rtl/refill_engine_chk.sv
module refill_engine_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETUP_CYC  = 10,
    parameter int CNT_W      = 16,
    parameter int BEATS      = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_req_o,
    input logic              mem_valid_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [CNT_W-1:0]  cycles_o
);

    logic [7:0] req_run;
    logic [7:0] beat_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         req_run <= '0;
        else if (mem_req_o) req_run <= req_run + 1'b1;
        else                req_run <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_seen <= '0;
        else if (!busy_o) beat_seen <= '0;
        else if (!mem_req_o && !done_o && mem_valid_i && beat_seen < 8'(BEATS))
            beat_seen <= beat_seen + 1'b1;
    end

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (mem_addr_o[OFF_W-1:0] == '0)); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$rose(busy_o)) |-> $stable(mem_addr_o)); // R2
    AST_SETUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_o && req_run != 0) |-> (req_run == 8'(SETUP_CYC))); // R3
    AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (beat_seen == 8'(BEATS))); // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R7
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R7
    AST_MIN_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cycles_o >= CNT_W'(SETUP_CYC + BEATS))); // R9

endmodule

bind refill_engine refill_engine_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .SETUP_CYC  (SETUP_CYC),
    .CNT_W      (CNT_W),
    .BEATS      (BEATS)
) u_chk (.*);

// File: tb/tb_refill_engine.sv
module tb_refill_engine;

    localparam int CLK_PERIOD = 10;
    localparam int BEATS      = 16;
    localparam int SETUP      = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  addr_i = '0;
    logic         busy_o, done_o, mem_req_o;
    logic [511:0] line_o;
    logic [15:0]  cycles_o;
    logic [31:0]  mem_addr_o;
    logic         mem_valid_i = 1'b0;
    logic [31:0]  mem_data_i = '0;

    int n_tests = 0;
    int n_fail  = 0;

    // memory model controls
    logic [31:0] gap_mask = '0;
    logic        junk_in_setup = 1'b0;
    bit          pending = 0;
    int          beat = 0;
    int          slot = 0;
    int          gaps_used = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refill_engine dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .addr_i (addr_i),
        .busy_o (busy_o), .done_o (done_o), .line_o (line_o),
        .cycles_o (cycles_o), .mem_req_o (mem_req_o), .mem_addr_o (mem_addr_o),
        .mem_valid_i (mem_valid_i), .mem_data_i (mem_data_i)
    );

    function automatic logic [31:0] wf(input logic [31:0] a, input int k);
        logic [7:0] kb;
        kb = 8'(k);
        return {kb ^ a[31:24], ~kb, kb + 8'h3C, kb ^ 8'h5A ^ a[13:6]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory side model
    always @(negedge clk) begin
        if (!rst_n) begin
            pending = 0; beat = 0; slot = 0; mem_valid_i = 1'b0;
        end else if (mem_req_o) begin
            pending = 1; beat = 0; slot = 0; gaps_used = 0;
            mem_valid_i = junk_in_setup;
            mem_data_i  = 32'hDEAD_BEEF;
        end else if (pending && beat < BEATS) begin
            if (slot < 32 && gap_mask[slot]) begin
                mem_valid_i = 1'b0;
                mem_data_i  = 32'h0BAD_0BAD;
                gaps_used++;
            end else begin
                mem_valid_i = 1'b1;
                mem_data_i  = wf(mem_addr_o, beat);
                beat++;
            end
            slot++;
        end else begin
            pending = 0;
            mem_valid_i = 1'b0;
        end
    end

    // inject: 0 none, 1 during setup, 2 during burst, 3 in the done cycle
    task automatic run_refill(input logic [31:0] a, input logic [31:0] gm,
                              input bit junk, input int inject);
        logic [31:0]  al;
        logic [511:0] exp_line;
        int           req_len, cyc;
        bit           busy_ok, addr_ok, seen_done;
        al = a & ~32'h3F;
        for (int k = 0; k < BEATS; k++) exp_line[32*k +: 32] = wf(al, k);
        gap_mask = gm;
        junk_in_setup = junk;
        @(negedge clk);
        start_i = 1'b1; addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
        req_len = 0; cyc = 0; busy_ok = 1; addr_ok = 1; seen_done = 0;
        while (!seen_done && cyc < 200) begin
            if (!busy_o) busy_ok = 0;
            if (mem_addr_o != al) addr_ok = 0;
            if (mem_req_o) req_len++;
            if (done_o) begin
                seen_done = 1;
                check(line_o == exp_line, "R5", "line contents",
                      64'(line_o ^ exp_line), 64'h0);
                check(cycles_o == 16'(26 + gaps_used), "R9", "cycle count",
                      64'(cycles_o), 64'(26 + gaps_used));
                if (inject == 3) begin start_i = 1'b1; addr_i = ~a; end
            end else begin
                start_i = 1'b0;
                if ((inject == 1 && cyc == 3) || (inject == 2 && cyc == 14)) begin
                    start_i = 1'b1; addr_i = a ^ 32'h0001_0040;
                end
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        check(seen_done, "R6", "done seen", 64'(seen_done), 64'h1);
        check(req_len == SETUP, "R3", "request length", 64'(req_len), 64'(SETUP));
        check(busy_ok, "R7", "busy held to done", 64'(busy_ok), 64'h1);
        check(addr_ok, "R2", "aligned address held", 64'(mem_addr_o), 64'(al));
        check(!done_o && !busy_o, "R6", "done one cycle, busy drops",
              64'({done_o, busy_o}), 64'h0);
        if (inject != 0) begin
            repeat (3) @(negedge clk);
            check(!busy_o && !mem_req_o, "R8", "no refill from ignored start",
                  64'({busy_o, mem_req_o}), 64'h0);
            check(mem_addr_o == al && cycles_o == 16'(26 + gaps_used), "R8",
                  "address and count kept", 64'(mem_addr_o), 64'(al));
        end
        check(cycles_o == 16'(26 + gaps_used), "R9", "count held after done",
              64'(cycles_o), 64'(26 + gaps_used));
        if (gm == 32'h0 || gm[0]) check(gaps_used == $countones(gm & 32'hFFFF) ||
                                        gm == 32'h0, "R4", "gap accounting",
                                        64'(gaps_used), 64'($countones(gm & 32'hFFFF)));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] addrs [4];
        logic [31:0] masks [4];
        addrs[0] = 32'hA7D3_04BE; addrs[1] = 32'h0000_0000;
        addrs[2] = 32'hFFFF_FFFF; addrs[3] = 32'h1089_4BC0;
        masks[0] = 32'h0;          masks[1] = 32'h0000_0001;
        masks[2] = 32'hAAAA_AAAA;  masks[3] = 32'h0000_C000;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !mem_req_o && cycles_o == 0, "R1",
              "reset outputs", 64'({busy_o, done_o, mem_req_o, cycles_o}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !mem_req_o, "R1", "idle after reset",
              64'({busy_o, mem_req_o}), 64'h0);
        // R4/R5 sweep over addresses and gap patterns
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                run_refill(addrs[i], masks[j], 1'b0, 0);
        // R3 junk valid during setup must be ignored
        run_refill(32'h1234_5678, 32'h0, 1'b1, 0);
        run_refill(32'h8765_4321, 32'h0000_0005, 1'b1, 0);
        // R8 starts while busy
        run_refill(32'h1085_4BCA, 32'h0, 1'b0, 1);
        run_refill(32'h1085_4BCA, 32'h0000_0030, 1'b0, 2);
        run_refill(32'h0000_1FC7, 32'h0, 1'b0, 3);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule